// File: doc/BRIEF.md
# Bitmap Prefix-Length Lookup Engine

This engine resolves the longest matching route prefix for an IPv4 destination address. It does not walk trie nodes. It keeps one on-chip bitmap for each prefix length from 1 up to a top level, 24 by default. The bitmap for level L has one bit for every possible L-bit address prefix. The engine probes these bitmaps from the top level downward, one read per cycle, and stops at the first set bit. That level is the longest match. The engine then reads one entry from that level's next-hop array, using the same prefix as the index.

Level 0 is never probed. It always counts as present and supplies the default route, so every lookup ends on a valid level. Routes longer than the top level are folded into the top level when the tables are built. Their next-hop entry holds the value zero. When the engine reads a zero entry, it reports a long-prefix result. In that case the chunk index it returns is the prefix that was used to read the entry, so a downstream stage can continue the search in off-chip storage.

The bitmaps and next-hop arrays are external synchronous memories with a one-cycle read latency. The engine drives their read ports directly. It takes a new address only while it is idle, and it reports each result with a single-cycle valid pulse.

Top module: `lpm_bitmap_engine`

## Requirements
- R1: While reset is held, and directly after it, in_ready is 1 and out_valid, bm_req and nh_req are 0.
- R2: in_ready is 1 only while no lookup is in progress. It drops in the cycle after an address is accepted. An address offered while in_ready is 0 is ignored and does not affect the result in progress.
- R3: The first bitmap read after acceptance is at level TOP_LVL. Each further read in a lookup is one level lower than the previous one. Level 0 is never read. The bitmap index for level L is the top L bits of the address, right-aligned.
- R4: out_len is the deepest level L in 1..TOP_LVL whose bitmap bit at the level-L index is 1. If no level has its bit set, out_len is 0.
- R5: The single next-hop read uses level out_len and that level's index. out_next_hop equals the returned entry.
- R6: An entry value of 0 sets out_long to 1, and out_chunk then equals the level-out_len index. A nonzero entry gives out_long 0 and out_chunk 0.
- R7: out_valid is a one-cycle pulse. It rises TOP_LVL − max(out_len,1) + 3 cycles after the accepting clock edge, and two cycles after the next-hop read.
- R8: The scan stops at the first set bit. A lookup issues exactly TOP_LVL − max(out_len,1) + 1 bitmap reads, so at most TOP_LVL reads. The bitmap and next-hop read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Engine idle; address accepted when in_valid is also 1 |
| in_addr | input | ADDR_W | Destination address |
| bm_req | output | 1 | Bitmap read strobe |
| bm_level | output | LVL_W | Bitmap level being read |
| bm_index | output | TOP_LVL | Bit index within that level's bitmap |
| bm_rdata | input | 1 | Bitmap bit, one cycle after bm_req |
| nh_req | output | 1 | Next-hop read strobe |
| nh_level | output | LVL_W | Next-hop array level |
| nh_index | output | TOP_LVL | Entry index within that array |
| nh_rdata | input | NH_W | Next-hop entry, one cycle after nh_req |
| out_valid | output | 1 | Result pulse |
| out_next_hop | output | NH_W | Entry read at the matched level |
| out_len | output | LVL_W | Matched prefix length |
| out_long | output | 1 | Entry was zero: longer prefix continues off-chip |
| out_chunk | output | TOP_LVL | Chunk index for a long-prefix result, else 0 |

## Verification
A wrong level counter or index shows up on the bitmap read port in the first cycle after acceptance. A wrong starting level or step would also break the descending read sequence within one cycle. A wrong stop condition shows up at the ports in two ways. If the scan stops too early or too late, the number of bitmap reads changes and out_len shifts. In the same lookup, the next-hop strobe appears in the wrong cycle and out_valid arrives earlier or later than the expected latency. A stale latched address or level shows up only in the fields of that lookup's result. The bench therefore compares every field of every result for a full address sweep, under several bitmap fill patterns.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_NHWAIT = 2'd2
  } lpm_state_e;

  // Top lvl bits of an aw-bit address, right-aligned; zero for level 0.
  function automatic logic [63:0] prefix_bits(input logic [63:0] a,
                                              input int aw,
                                              input int lvl);
    if (lvl == 0) prefix_bits = '0;
    else          prefix_bits = a >> (aw - lvl);
  endfunction

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_scan.sv
module lpm_scan #(
  parameter int ADDR_W  = 32,
  parameter int TOP_LVL = 24,
  parameter int LVL_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               active,
  input  logic [ADDR_W-1:0]  addr,
  output logic               bm_req,
  output logic [LVL_W-1:0]   bm_level,
  output logic [TOP_LVL-1:0] bm_index,
  input  logic               bm_rdata,
  output logic               done,
  output logic [LVL_W-1:0]   sel_lvl
);

  logic [LVL_W-1:0] cur_q, cur_d;
  logic             pend_vld_q, pend_vld_d;
  logic [LVL_W-1:0] pend_lvl_q, pend_lvl_d;
  logic             hit;
  logic             last_lvl;

  // The probe result issued last cycle is evaluated while the next one issues.
  always_comb begin
    hit      = active && pend_vld_q && bm_rdata;
    last_lvl = (cur_q == '0);
    done     = active && (hit || last_lvl);
    sel_lvl  = hit ? pend_lvl_q : '0;
    bm_req   = active && !hit && !last_lvl;
    bm_level = cur_q;
    bm_index = TOP_LVL'(lpm_pkg::prefix_bits(64'(addr), ADDR_W, int'(cur_q)));
  end

  always_comb begin
    cur_d      = cur_q;
    pend_vld_d = 1'b0;
    pend_lvl_d = pend_lvl_q;
    if (start) begin
      cur_d = LVL_W'(TOP_LVL);
    end else if (bm_req) begin
      cur_d      = cur_q - LVL_W'(1);
      pend_vld_d = 1'b1;
      pend_lvl_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      pend_vld_q <= 1'b0;
      pend_lvl_q <= '0;
    end else begin
      cur_q      <= cur_d;
      pend_vld_q <= pend_vld_d;
      pend_lvl_q <= pend_lvl_d;
    end
  end

endmodule

// File: rtl/lpm_result.sv
module lpm_result #(
  parameter int NH_W    = 8,
  parameter int TOP_LVL = 24,
  parameter int LVL_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LVL_W-1:0]   lvl_in,
  input  logic [TOP_LVL-1:0] idx_in,
  input  logic [NH_W-1:0]    nh_rdata,
  output logic               out_valid,
  output logic [NH_W-1:0]    out_next_hop,
  output logic [LVL_W-1:0]   out_len,
  output logic               out_long,
  output logic [TOP_LVL-1:0] out_chunk
);

  logic               vld_q, vld_d;
  logic [NH_W-1:0]    nh_q, nh_d;
  logic [LVL_W-1:0]   len_q, len_d;
  logic               long_q, long_d;
  logic [TOP_LVL-1:0] chunk_q, chunk_d;
  logic               is_long;

  always_comb begin
    is_long = (nh_rdata == '0);
    vld_d   = capture;
    nh_d    = nh_q;
    len_d   = len_q;
    long_d  = long_q;
    chunk_d = chunk_q;
    if (capture) begin
      nh_d    = nh_rdata;
      len_d   = lvl_in;
      long_d  = is_long;
      chunk_d = is_long ? idx_in : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      nh_q    <= '0;
      len_q   <= '0;
      long_q  <= 1'b0;
      chunk_q <= '0;
    end else begin
      vld_q   <= vld_d;
      nh_q    <= nh_d;
      len_q   <= len_d;
      long_q  <= long_d;
      chunk_q <= chunk_d;
    end
  end

  assign out_valid    = vld_q;
  assign out_next_hop = nh_q;
  assign out_len      = len_q;
  assign out_long     = long_q;
  assign out_chunk    = chunk_q;

endmodule

// File: rtl/lpm_bitmap_engine.sv
module lpm_bitmap_engine #(
  parameter int ADDR_W  = 32,
  parameter int TOP_LVL = 24,
  parameter int NH_W    = 8,
  localparam int LVL_W  = $clog2(TOP_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               bm_req,
  output logic [LVL_W-1:0]   bm_level,
  output logic [TOP_LVL-1:0] bm_index,
  input  logic               bm_rdata,
  output logic               nh_req,
  output logic [LVL_W-1:0]   nh_level,
  output logic [TOP_LVL-1:0] nh_index,
  input  logic [NH_W-1:0]    nh_rdata,
  output logic               out_valid,
  output logic [NH_W-1:0]    out_next_hop,
  output logic [LVL_W-1:0]   out_len,
  output logic               out_long,
  output logic [TOP_LVL-1:0] out_chunk
);

  import lpm_pkg::*;

  logic             rst_q_n;
  lpm_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LVL_W-1:0] res_lvl_q, res_lvl_d;
  logic             accept;
  logic             scanning;
  logic             scan_done;
  logic [LVL_W-1:0] scan_lvl;
  logic             capture;
  logic [TOP_LVL-1:0] res_idx;

  lpm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  always_comb begin
    in_ready = (state_q == ST_IDLE);
    accept   = in_valid && in_ready;
    scanning = (state_q == ST_SCAN);
    capture  = (state_q == ST_NHWAIT);
  end

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    res_lvl_d = res_lvl_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SCAN;
        addr_d  = in_addr;
      end
      ST_SCAN: if (scan_done) begin
        state_d   = ST_NHWAIT;
        res_lvl_d = scan_lvl;
      end
      ST_NHWAIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      res_lvl_q <= '0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      res_lvl_q <= res_lvl_d;
    end
  end

  lpm_scan #(
    .ADDR_W  (ADDR_W),
    .TOP_LVL (TOP_LVL),
    .LVL_W   (LVL_W)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (accept),
    .active   (scanning),
    .addr     (addr_q),
    .bm_req   (bm_req),
    .bm_level (bm_level),
    .bm_index (bm_index),
    .bm_rdata (bm_rdata),
    .done     (scan_done),
    .sel_lvl  (scan_lvl)
  );

  // Next-hop read goes out in the same cycle the matching level is known.
  always_comb begin
    nh_req   = scan_done;
    nh_level = scan_lvl;
    nh_index = TOP_LVL'(prefix_bits(64'(addr_q), ADDR_W, int'(scan_lvl)));
    res_idx  = TOP_LVL'(prefix_bits(64'(addr_q), ADDR_W, int'(res_lvl_q)));
  end

  lpm_result #(
    .NH_W    (NH_W),
    .TOP_LVL (TOP_LVL),
    .LVL_W   (LVL_W)
  ) u_result (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .capture      (capture),
    .lvl_in       (res_lvl_q),
    .idx_in       (res_idx),
    .nh_rdata     (nh_rdata),
    .out_valid    (out_valid),
    .out_next_hop (out_next_hop),
    .out_len      (out_len),
    .out_long     (out_long),
    .out_chunk    (out_chunk)
  );

endmodule

// File: rtl/lpm_bitmap_engine_chk.sv
module lpm_bitmap_engine_chk #(
  parameter int TOP_LVL = 24,
  parameter int LVL_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               bm_req,
  input logic [LVL_W-1:0]   bm_level,
  input logic               nh_req,
  input logic [LVL_W-1:0]   nh_level,
  input logic               out_valid,
  input logic [LVL_W-1:0]   out_len,
  input logic               out_long,
  input logic [TOP_LVL-1:0] out_chunk
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R2

  AST_FIRST_PROBE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> bm_req && bm_level == LVL_W'(TOP_LVL)); // R3

  AST_PROBE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && $past(bm_req) |-> bm_level == $past(bm_level) - LVL_W'(1)); // R3

  AST_NO_ROOT_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> bm_level != '0); // R3

  AST_NH_FOLLOWS_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    nh_req |-> $past(bm_req) && (($past(bm_level) == nh_level) ||
               (nh_level == '0 && $past(bm_level) == LVL_W'(1)))); // R5

  AST_SHORT_NO_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_long |-> out_chunk == '0); // R6

  AST_OUT_AFTER_NH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(nh_req, 2)); // R7

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len <= LVL_W'(TOP_LVL)); // R4

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bm_req && nh_req)); // R8

endmodule

bind lpm_bitmap_engine lpm_bitmap_engine_chk #(
  .TOP_LVL (TOP_LVL),
  .LVL_W   (LVL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .bm_req    (bm_req),
  .bm_level  (bm_level),
  .nh_req    (nh_req),
  .nh_level  (nh_level),
  .out_valid (out_valid),
  .out_len   (out_len),
  .out_long  (out_long),
  .out_chunk (out_chunk)
);

// File: tb/lpm_bitmap_engine_bench.sv
`timescale 1ns/1ps
module lpm_bitmap_engine_bench;

  localparam int AW   = 10;
  localparam int TOP  = 6;
  localparam int NHW  = 8;
  localparam int LW   = $clog2(TOP + 1);
  localparam int NIDX = 1 << TOP;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [AW-1:0]  in_addr;
  logic           bm_req;
  logic [LW-1:0]  bm_level;
  logic [TOP-1:0] bm_index;
  logic           bm_rdata;
  logic           nh_req;
  logic [LW-1:0]  nh_level;
  logic [TOP-1:0] nh_index;
  logic [NHW-1:0] nh_rdata;
  logic           out_valid;
  logic [NHW-1:0] out_next_hop;
  logic [LW-1:0]  out_len;
  logic           out_long;
  logic [TOP-1:0] out_chunk;

  int total;
  int bad;

  logic           bm_tab [0:TOP][0:NIDX-1];
  logic [NHW-1:0] nh_tab [0:TOP][0:NIDX-1];

  lpm_bitmap_engine #(.ADDR_W(AW), .TOP_LVL(TOP), .NH_W(NHW)) u_lpm_bitmap_engine (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_addr (in_addr), .bm_req (bm_req), .bm_level (bm_level),
    .bm_index (bm_index), .bm_rdata (bm_rdata), .nh_req (nh_req),
    .nh_level (nh_level), .nh_index (nh_index), .nh_rdata (nh_rdata),
    .out_valid (out_valid), .out_next_hop (out_next_hop), .out_len (out_len),
    .out_long (out_long), .out_chunk (out_chunk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // One-cycle-latency table models
  always @(posedge clk) begin
    if (bm_req) bm_rdata <= bm_tab[bm_level][bm_index];
    if (nh_req) nh_rdata <= nh_tab[nh_level][nh_index];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pfx(input int a, input int l);
    return (l == 0) ? 0 : (a >> (AW - l));
  endfunction

  task automatic fill(input int k);
    for (int l = 0; l <= TOP; l++) begin
      for (int i = 0; i < NIDX; i++) begin
        case (k)
          0: bm_tab[l][i] = 1'b0;
          1: bm_tab[l][i] = (l == TOP);
          2: bm_tab[l][i] = (((i * 5 + l * 3) % 4) == 1);
          3: bm_tab[l][i] = (((i ^ (l * 11)) % 7) == 0);
          default: bm_tab[l][i] = (l == 3 && i % 2 == 0) || (l == 5 && i % 3 == 0);
        endcase
        if (((i + l + k) % 6) == 0) nh_tab[l][i] = '0;
        else nh_tab[l][i] = NHW'(((l * 37 + i * 13 + k * 7) % 251) + 1);
      end
    end
  endtask

  task automatic lookup(input int a, input bit junk);
    int exp_l, idx, probes, c, exp_probe, lo;
    bit seen;
    logic [NHW-1:0] exp_nh;
    exp_l = 0;
    for (int l = TOP; l >= 1; l--) begin
      if (exp_l == 0 && bm_tab[l][pfx(a, l)]) exp_l = l;
    end
    idx    = pfx(a, exp_l);
    exp_nh = nh_tab[exp_l][idx];
    lo     = (exp_l < 1) ? 1 : exp_l;

    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready when idle", int'(in_ready), 1);
    in_valid = 1'b1;
    in_addr  = AW'(a);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
    chk(bm_req && bm_level == LW'(TOP), "R3 first probe at top", int'(bm_level), TOP);
    if (junk) begin
      in_valid = 1'b1;
      in_addr  = ~AW'(a);
    end else begin
      in_valid = 1'b0;
    end
    probes = 0;
    c      = 0;
    seen   = 1'b0;
    while (!seen && c < 64) begin
      if (bm_req) begin
        exp_probe = TOP - probes;
        chk(bm_level == LW'(exp_probe), "R3 probe level", int'(bm_level), exp_probe);
        chk(int'(bm_index) == pfx(a, exp_probe), "R3 probe index", int'(bm_index), pfx(a, exp_probe));
        probes++;
      end
      if (out_valid) begin
        seen = 1'b1;
      end else begin
        @(negedge clk);
        c++;
        if (c == 1) in_valid = 1'b0;
      end
    end
    chk(seen, "R7 result arrives", int'(seen), 1);
    chk(c == TOP - lo + 3, "R7 latency", c, TOP - lo + 3);
    chk(probes == TOP - lo + 1, "R8 probe count", probes, TOP - lo + 1);
    chk(int'(out_len) == exp_l, "R4 matched length", int'(out_len), exp_l);
    chk(out_next_hop == exp_nh, "R5 next hop", int'(out_next_hop), int'(exp_nh));
    chk(out_long == (exp_nh == '0), "R6 long flag", int'(out_long), int'(exp_nh == '0));
    chk(int'(out_chunk) == ((exp_nh == '0) ? idx : 0), "R6 chunk index",
        int'(out_chunk), (exp_nh == '0) ? idx : 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 single-cycle pulse", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total    = 0;
    bad      = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_addr  = '0;
    fill(0);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no result in reset", int'(out_valid), 0);
    chk(bm_req == 1'b0 && nh_req == 1'b0, "R1 no reads in reset",
        int'(bm_req) + int'(nh_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset",
        int'(in_ready), 1);
    for (int k = 0; k < 5; k++) begin
      fill(k);
      for (int a = 0; a < (1 << AW); a++) begin
        lookup(a, (a % 3) == 0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule